// File: doc/BRIEF.md
# Voltage and Frequency Operating Point Sequencer

This block steers a processor core between a small set of fixed supply and clock operating points. A workload monitor presents a requested performance level. Whenever the block is idle and that level differs from the present one, the block starts a single transition straight to the requested point. It drives a supply voltage code to the regulator and a clock frequency code to the clock generator. It reports busy until both have settled.

The ordering of each transition depends on its direction. This keeps the clock within what the present supply can sustain at every cycle. On a raise, the voltage moves first and the block waits for the regulator's settled acknowledge before it changes the clock. On a lower, the clock slows first and is given a programmable settle time before the voltage code drops. Every transition ends with a frequency settle time or a voltage acknowledge, so the next transition starts from a stable state.

Top module: `dvs_opp_sequencer`

## Requirements
- R1: After reset the block sits at level 0 (voltage code 80, frequency code 300) with busy low.
- R2: In every cycle the frequency code is no higher than the highest frequency of any table point whose voltage is at or below the present voltage code.
- R3: Only table pairs are emitted. Levels 0..6 map to voltage codes (in 10 mV units) 80, 87, 95, 105, 115, 125, 130 and to frequency codes (in MHz) 300, 433, 533, 667, 800, 900, 1000.
- R4: On a raise, the voltage code changes in the first cycle after the request is accepted, and the frequency code changes only after the voltage-settled acknowledge is seen.
- R5: On a lower, the frequency code changes in the first cycle after the request is accepted, and the voltage code drops only afterwards.
- R6: Each frequency change is followed by exactly SETTLE_CYCLES cycles before the next step. On a raise, busy falls SETTLE_CYCLES cycles after the frequency change. On a lower, the voltage drops SETTLE_CYCLES cycles after the frequency change.
- R7: Busy is high from the cycle after a request is accepted until the transition ends, and the request input is not sampled while busy.
- R8: A request equal to the present level is ignored and busy stays low.
- R9: A jump across several levels changes each code exactly once, straight to the target.
- R10: A request value of 7 is treated as level 6.
- R11: When busy falls, both codes equal the target point's table values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_level_i | input | 3 | Requested performance level |
| volt_ack_i | input | 1 | Regulator reports that the supply has settled at the present code |
| volt_code_o | output | 8 | Supply voltage code, in 10 mV units |
| freq_code_o | output | 10 | Clock frequency code, in MHz |
| busy_o | output | 1 | Transition in progress |

## Verification
The bench builds the block with SETTLE_CYCLES set to 5. At that setting every raise, lower and multi-level jump completes in a few tens of cycles, and the exact settle spacing can be counted cycle by cycle. A bench regulator model holds the acknowledge low for a random delay of 0 to 3 cycles after each voltage change. This exercises both the immediate-acknowledge case and waiting in the voltage phase. Random requests, including the out-of-range value 7 and repeats of the present level, are mixed with directed jumps across the whole table.

// File: rtl/dvs_pkg.sv
package dvs_pkg;
  localparam int unsigned NUM_PTS = 7;
  localparam int unsigned LVL_W   = $clog2(NUM_PTS);
  localparam int unsigned VCODE_W = 8;
  localparam int unsigned FCODE_W = 10;

  typedef logic [LVL_W-1:0]   lvl_t;
  typedef logic [VCODE_W-1:0] vcode_t;
  typedef logic [FCODE_W-1:0] fcode_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_UP_V,
    ST_UP_F,
    ST_DN_F,
    ST_DN_V
  } seq_st_e;

  // supply in 10 mV steps
  function automatic vcode_t pt_volt(lvl_t l);
    case (l)
      3'd0:    pt_volt = vcode_t'(80);
      3'd1:    pt_volt = vcode_t'(87);
      3'd2:    pt_volt = vcode_t'(95);
      3'd3:    pt_volt = vcode_t'(105);
      3'd4:    pt_volt = vcode_t'(115);
      3'd5:    pt_volt = vcode_t'(125);
      default: pt_volt = vcode_t'(130);
    endcase
  endfunction

  // clock in MHz
  function automatic fcode_t pt_freq(lvl_t l);
    case (l)
      3'd0:    pt_freq = fcode_t'(300);
      3'd1:    pt_freq = fcode_t'(433);
      3'd2:    pt_freq = fcode_t'(533);
      3'd3:    pt_freq = fcode_t'(667);
      3'd4:    pt_freq = fcode_t'(800);
      3'd5:    pt_freq = fcode_t'(900);
      default: pt_freq = fcode_t'(1000);
    endcase
  endfunction
endpackage

// File: rtl/dvs_req_clamp.sv
module dvs_req_clamp
  import dvs_pkg::*;
(
  input  lvl_t req_i,
  output lvl_t lvl_o
);
  localparam lvl_t TOP_LVL = lvl_t'(NUM_PTS - 1);

  assign lvl_o = (req_i > TOP_LVL) ? TOP_LVL : req_i;
endmodule

// File: rtl/dvs_settle_timer.sv
module dvs_settle_timer #(
  parameter int unsigned SETTLE_CYCLES = 150000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic run_i,
  output logic expired_o
);
  localparam int unsigned CNT_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(SETTLE_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (load_i)                  cnt_q <= LOAD_VAL;
    else if (run_i && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/dvs_seq_fsm.sv
module dvs_seq_fsm
  import dvs_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  lvl_t req_lvl_i,
  input  logic volt_ack_i,
  input  logic expired_i,
  output lvl_t volt_lvl_o,
  output lvl_t freq_lvl_o,
  output logic busy_o,
  output logic tmr_load_o,
  output logic tmr_run_o
);
  seq_st_e st_q, st_d;
  lvl_t    vl_q, vl_d, fl_q, fl_d, tgt_q, tgt_d;

  always_comb begin
    st_d       = st_q;
    vl_d       = vl_q;
    fl_d       = fl_q;
    tgt_d      = tgt_q;
    tmr_load_o = 1'b0;
    tmr_run_o  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (req_lvl_i > fl_q) begin
          tgt_d = req_lvl_i;
          vl_d  = req_lvl_i;     // supply leads on the way up
          st_d  = ST_UP_V;
        end else if (req_lvl_i < fl_q) begin
          tgt_d      = req_lvl_i;
          fl_d       = req_lvl_i; // clock leads on the way down
          tmr_load_o = 1'b1;
          st_d       = ST_DN_F;
        end
      end
      ST_UP_V: begin
        if (volt_ack_i) begin
          fl_d       = tgt_q;
          tmr_load_o = 1'b1;
          st_d       = ST_UP_F;
        end
      end
      ST_UP_F: begin
        tmr_run_o = 1'b1;
        if (expired_i) st_d = ST_IDLE;
      end
      ST_DN_F: begin
        tmr_run_o = 1'b1;
        if (expired_i) begin
          vl_d = tgt_q;
          st_d = ST_DN_V;
        end
      end
      ST_DN_V: begin
        if (volt_ack_i) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      vl_q  <= '0;
      fl_q  <= '0;
      tgt_q <= '0;
    end else begin
      st_q  <= st_d;
      vl_q  <= vl_d;
      fl_q  <= fl_d;
      tgt_q <= tgt_d;
    end
  end

  assign volt_lvl_o = vl_q;
  assign freq_lvl_o = fl_q;
  assign busy_o     = (st_q != ST_IDLE);
endmodule

// File: rtl/dvs_point_rom.sv
module dvs_point_rom
  import dvs_pkg::*;
(
  input  lvl_t   volt_lvl_i,
  input  lvl_t   freq_lvl_i,
  output vcode_t volt_code_o,
  output fcode_t freq_code_o
);
  assign volt_code_o = pt_volt(volt_lvl_i);
  assign freq_code_o = pt_freq(freq_lvl_i);
endmodule

// File: rtl/dvs_opp_sequencer.sv
module dvs_opp_sequencer
  import dvs_pkg::*;
#(
  parameter int unsigned SETTLE_CYCLES = 150000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [LVL_W-1:0]   req_level_i,
  input  logic               volt_ack_i,
  output logic [VCODE_W-1:0] volt_code_o,
  output logic [FCODE_W-1:0] freq_code_o,
  output logic               busy_o
);
  lvl_t req_lvl, volt_lvl, freq_lvl;
  logic tmr_load, tmr_run, tmr_expired;

  dvs_req_clamp i_clamp (
    .req_i (req_level_i),
    .lvl_o (req_lvl)
  );

  dvs_seq_fsm i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_lvl_i  (req_lvl),
    .volt_ack_i (volt_ack_i),
    .expired_i  (tmr_expired),
    .volt_lvl_o (volt_lvl),
    .freq_lvl_o (freq_lvl),
    .busy_o     (busy_o),
    .tmr_load_o (tmr_load),
    .tmr_run_o  (tmr_run)
  );

  dvs_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) i_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (tmr_load),
    .run_i     (tmr_run),
    .expired_o (tmr_expired)
  );

  dvs_point_rom i_rom (
    .volt_lvl_i  (volt_lvl),
    .freq_lvl_i  (freq_lvl),
    .volt_code_o (volt_code_o),
    .freq_code_o (freq_code_o)
  );
endmodule

// File: rtl/dvs_opp_sequencer_chk.sv
module dvs_opp_sequencer_chk
  import dvs_pkg::*;
(
  input logic clk_i,
  input logic rst_ni,
  input lvl_t req_level_i,
  input logic busy_i,
  input lvl_t volt_lvl_i,
  input lvl_t freq_lvl_i
);
  lvl_t req_c;
  assign req_c = (req_level_i > lvl_t'(NUM_PTS - 1)) ? lvl_t'(NUM_PTS - 1) : req_level_i;

  a_r2_freq_within_supply: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freq_lvl_i <= volt_lvl_i);

  a_r3_levels_in_table: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (volt_lvl_i < lvl_t'(NUM_PTS)) && (freq_lvl_i < lvl_t'(NUM_PTS)));

  a_r4_raise_after_supply: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (freq_lvl_i > $past(freq_lvl_i)) |-> ($past(volt_lvl_i) >= freq_lvl_i));

  a_r5_lower_after_clock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (volt_lvl_i < $past(volt_lvl_i)) |-> ($past(freq_lvl_i) == volt_lvl_i));

  a_r8_equal_req_stays_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && req_c == freq_lvl_i) |=> !busy_i);

  a_r11_idle_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> (volt_lvl_i == freq_lvl_i));
endmodule

bind dvs_opp_sequencer dvs_opp_sequencer_chk i_dvs_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_level_i (req_level_i),
  .busy_i      (busy_o),
  .volt_lvl_i  (volt_lvl),
  .freq_lvl_i  (freq_lvl)
);

// File: tb/test_dvs_opp_sequencer.sv
module test_dvs_opp_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] req = 3'd0;
  logic       ack = 1'b1;
  logic [7:0] vcode;
  logic [9:0] fcode;
  logic       busy;

  int total = 0;
  int bad = 0;
  int ack_dly = 0;
  int ack_cnt = 0;
  int last_v = 80;

  always #(CLK_PERIOD/2) clk = ~clk;

  dvs_opp_sequencer #(.SETTLE_CYCLES(SETTLE)) i_dvs_opp_sequencer (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .req_level_i (req),
    .volt_ack_i  (ack),
    .volt_code_o (vcode),
    .freq_code_o (fcode),
    .busy_o      (busy)
  );

  function automatic int exp_v(int l);
    case (l > 6 ? 6 : l)
      0: return 80;  1: return 87;  2: return 95;  3: return 105;
      4: return 115; 5: return 125; default: return 130;
    endcase
  endfunction

  function automatic int exp_f(int l);
    case (l > 6 ? 6 : l)
      0: return 300; 1: return 433; 2: return 533; 3: return 667;
      4: return 800; 5: return 900; default: return 1000;
    endcase
  endfunction

  function automatic int fmax_for_v(int v);
    int best = -1;
    for (int i = 0; i < 7; i++) if (exp_v(i) <= v) best = exp_f(i);
    return best;
  endfunction

  function automatic bit in_vtab(int v);
    for (int i = 0; i < 7; i++) if (exp_v(i) == v) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit in_ftab(int f);
    for (int i = 0; i < 7; i++) if (exp_f(i) == f) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // regulator model: ack low for ack_dly cycles after each code change
  always @(negedge clk) begin
    if (!rst_n) begin
      ack = 1'b1; last_v = 80; ack_cnt = 0;
    end else if (int'(vcode) != last_v) begin
      last_v  = int'(vcode);
      ack_cnt = ack_dly;
      ack     = (ack_dly == 0);
    end else if (ack_cnt > 0) begin
      ack_cnt--;
      if (ack_cnt == 0) ack = 1'b1;
    end
  end

  // every-cycle monitor
  always @(negedge clk) begin
    if (rst_n) begin
      check(int'(fcode) <= fmax_for_v(int'(vcode)), "R2 freq within supply",
            int'(fcode), fmax_for_v(int'(vcode)));
      check(in_vtab(int'(vcode)) && in_ftab(int'(fcode)), "R3 table codes",
            int'(vcode), int'(fcode));
    end
  end

  task automatic do_req(int lvl, int adly, bit glitch);
    int tgt, cur_v, prev_v, prev_f, vchg, fchg, t_v, t_f, cyc;
    bit up;
    tgt = (lvl > 6) ? 6 : lvl;
    ack_dly = adly;
    @(negedge clk);
    cur_v = int'(vcode);
    prev_v = int'(vcode);
    prev_f = int'(fcode);
    req = 3'(lvl);
    @(negedge clk);
    if (exp_v(tgt) == cur_v) begin
      for (int k = 0; k < 3; k++) begin
        check(!busy, "R8 equal request ignored", int'(busy), 0);
        check(int'(vcode) == cur_v, "R8 code unchanged", int'(vcode), cur_v);
        @(negedge clk);
      end
      return;
    end
    up = exp_v(tgt) > cur_v;
    check(busy, "R7 busy after accept", int'(busy), 1);
    vchg = 0; fchg = 0; t_v = -1; t_f = -1; cyc = 0;
    while (cyc < 1000) begin
      if (int'(vcode) != prev_v) begin vchg++; t_v = cyc; prev_v = int'(vcode); end
      if (int'(fcode) != prev_f) begin fchg++; t_f = cyc; prev_f = int'(fcode); end
      if (!busy) break;
      if (glitch && cyc == 1) req = 3'(tgt == 0 ? 6 : 0);
      if (glitch && cyc == 2) req = 3'(lvl);
      @(negedge clk);
      cyc++;
    end
    check(int'(vcode) == exp_v(tgt), lvl == 7 ? "R10 clamp volt" : "R11 final volt",
          int'(vcode), exp_v(tgt));
    check(int'(fcode) == exp_f(tgt), lvl == 7 ? "R10 clamp freq" : "R11 final freq",
          int'(fcode), exp_f(tgt));
    check(vchg == 1 && fchg == 1, "R9 single step", vchg * 10 + fchg, 11);
    if (up) begin
      check(t_v == 0, "R4 volt leads", t_v, 0);
      check(t_f >= t_v + 1 + adly, "R4 freq after ack", t_f, t_v + 1 + adly);
      check(cyc - t_f == SETTLE, "R6 settle on raise", cyc - t_f, SETTLE);
    end else begin
      check(t_f == 0, "R5 freq leads", t_f, 0);
      check(t_v - t_f == SETTLE, "R6 settle on lower", t_v - t_f, SETTLE);
    end
    @(negedge clk);
    check(!busy, "R7 request during busy ignored", int'(busy), 0);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(int'(vcode) == 80, "R1 reset volt", int'(vcode), 80);
    check(int'(fcode) == 300, "R1 reset freq", int'(fcode), 300);
    check(!busy, "R1 reset busy", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(int'(vcode) == 80 && int'(fcode) == 300 && !busy, "R1 after release",
          int'(vcode), 80);
    do_req(0, 0, 1'b0);  // R8 equal at reset
    do_req(3, 0, 1'b0);
    do_req(3, 2, 1'b0);
    do_req(0, 2, 1'b0);
    do_req(6, 3, 1'b0);  // R9 full jump
    do_req(7, 0, 1'b0);  // R10 clamp to present level
    do_req(1, 1, 1'b0);
    do_req(7, 1, 1'b0);  // R10 clamp raise
    do_req(2, 0, 1'b1);  // R7 glitch while busy
    do_req(5, 2, 1'b1);
    for (int n = 0; n < 60; n++)
      do_req(int'($urandom_range(0, 7)), int'($urandom_range(0, 3)), 1'($urandom_range(0, 1)));
    finish_run();
  end
endmodule